// File: doc/BRIEF.md
# Masked Fault Alert with Alert-Response Reply

This block turns a set of sticky fault flags into an active-low, open-drain alert request. A host-owned mask selects which faults may raise the alert. The alert asserts only when a masked fault condition appears. It stays asserted until the condition disappears, or until a bus master has been told which device raised it.

The block contains a small two-wire bus target that only watches for two things. The first is a read of the shared alert-response address, 0001100 followed by a read bit of 1. When this device has an alert pending, it acknowledges that read and returns its own 7-bit address, most significant bit first, with a released 1 as the last bit. Several devices may answer at once. The bus is wired-AND, so the device with the lower address wins. A device that loses stops driving for the rest of the byte and keeps its alert asserted. The second thing the target watches for is a START followed by this device's own address. That also releases a pending alert. The bus inputs are already synchronized to `clk`, and the two outputs enable pull-down drivers.

Top module: `alert_resp_target`

## Requirements
- R1: The alert output is asserted one clock after a masked fault condition (fault AND mask nonzero) first appears. It is deasserted one clock after no bit of fault AND mask is set.
- R2: During reset both pull-down outputs are 0. While the mask is all zeros, no fault pattern asserts the alert.
- R3: A first byte of 0001100 followed by a read bit of 1 is acknowledged by pulling SDA low during the ninth clock, but only while this device's alert is asserted. Otherwise SDA stays released for the whole transaction.
- R4: After that acknowledge, the reply byte is the 7-bit device address, most significant bit first, followed by a released 1. SDA is changed only while SCL is low.
- R5: If the block releases SDA for a 1 but reads 0 while SCL is high, it releases SDA for the rest of the byte and keeps its alert asserted.
- R6: When all eight reply bits are sent without losing arbitration, the alert is released.
- R7: A first byte whose upper seven bits equal the device address, with either read/write bit, releases a pending alert and is not acknowledged. Any other non-matching address leaves the alert unchanged.
- R8: Once released, the alert is asserted again only on a new rising edge of the masked fault condition. It is not asserted again while the same condition persists, even if the set of active fault bits changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault | input | NFAULT | Sticky fault flags |
| mask | input | NFAULT | Per-fault alert enable, 1 = may alert |
| dev_addr | input | AW | This device's 7-bit bus address |
| scl | input | 1 | Synchronized bus clock level |
| sda | input | 1 | Synchronized bus data level |
| sda_pull | output | 1 | 1 = pull SDA low |
| alert_pull | output | 1 | 1 = pull the alert line low |

## Verification
The bench sweeps every fault pattern against sixteen masks, including all-zero. A gate that ignored the mask, or that used OR in place of AND, would assert the alert where the arithmetic says it should not. It runs alert-response reads for four device addresses against a modelled competitor at each of those addresses and with no competitor, including equal addresses. A design that arbitrated on the wrong bit order, kept driving after a loss, or released its alert on a lost round returns the wrong byte or the wrong alert level. Three further cases are covered. A response read with no alert pending must see no acknowledge. A direct own-address hit must release the alert without an acknowledge. A persisting or reshuffled fault condition after release must not raise the alert again, which would catch a design that re-arms on the level instead of the edge.

// File: rtl/alert_resp_target.sv
module alert_resp_target #(
  parameter int NFAULT = 8,
  parameter int AW = 7,
  parameter logic [AW-1:0] RESP_ADDR = 7'b0001100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NFAULT-1:0] fault,
  input  logic [NFAULT-1:0] mask,
  input  logic [AW-1:0]     dev_addr,
  input  logic              scl,
  input  logic              sda,
  output logic              sda_pull,
  output logic              alert_pull
);
  localparam int BITS = AW + 1;
  localparam int CW = $clog2(BITS + 1);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_ACK, S_SEND, S_DONE} st_t;

  st_t          st;
  logic         scl_q, sda_q, masked_q, pending, lost;
  logic [AW:0]  shreg, txsh;
  logic [CW-1:0] cnt;

  wire masked   = |(fault & mask);
  wire scl_rise = scl & ~scl_q;
  wire scl_fall = ~scl & scl_q;
  wire start    = scl & scl_q & sda_q & ~sda;
  wire stop     = scl & scl_q & ~sda_q & sda;
  wire tx_bit   = txsh[AW];
  wire lose_now = tx_bit & ~sda;

  wire served  = (st == S_SEND) && scl_rise && (cnt == CW'(BITS - 1)) && !lost && !lose_now;
  wire own_hit = (st == S_ADDR) && scl_fall && (cnt == CW'(BITS)) && (shreg[AW:1] == dev_addr);
  wire ara_hit = (shreg == {RESP_ADDR, 1'b1}) && pending;

  assign alert_pull = pending;
  assign sda_pull   = (st == S_ACK) || ((st == S_SEND) && !lost && !tx_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      masked_q <= 1'b0;
      pending  <= 1'b0;
      lost     <= 1'b0;
      shreg    <= '0;
      txsh     <= '1;
      cnt      <= '0;
    end else begin
      scl_q    <= scl;
      sda_q    <= sda;
      masked_q <= masked;
      pending  <= masked & (pending | ~masked_q) & ~served & ~own_hit;
      if (start) begin
        st  <= S_ADDR;
        cnt <= '0;
      end else if (stop) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise && cnt < CW'(BITS)) begin
              shreg <= {shreg[AW-1:0], sda};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CW'(BITS)) begin
              st <= ara_hit ? S_ACK : S_DONE;
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              st   <= S_SEND;
              cnt  <= '0;
              lost <= 1'b0;
              txsh <= {dev_addr, 1'b1};
            end
          end
          S_SEND: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
              if (lose_now) lost <= 1'b1;
            end else if (scl_fall) begin
              if (cnt == CW'(BITS)) st <= S_DONE;
              else txsh <= {txsh[AW-1:0], 1'b1};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module alert_resp_target_chk #(
  parameter int NFAULT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NFAULT-1:0] fault,
  input logic [NFAULT-1:0] mask,
  input logic              scl,
  input logic              sda_pull,
  input logic              alert_pull
);
  assert_quiet_when_unmasked_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(fault & mask)) |=> !alert_pull);
  assert_raise_needs_fault_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alert_pull) |-> $past(|(fault & mask)));
  assert_mask_zero_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |=> !alert_pull);
  assert_drive_on_low_clock_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl);
endmodule

bind alert_resp_target alert_resp_target_chk #(.NFAULT(NFAULT)) chk (
  .clk(clk), .rst_n(rst_n), .fault(fault), .mask(mask),
  .scl(scl), .sda_pull(sda_pull), .alert_pull(alert_pull)
);

// File: tb/alert_resp_target_test.sv
module alert_resp_target_test;
  logic clk = 0, rst_n = 0;
  logic [7:0] fault = 0, mask = 0;
  logic [6:0] dev_addr = 7'h2A;
  logic scl = 1, sda_m = 1, comp_pull = 0;
  logic sda_pull, alert_pull;
  wire sda_line = sda_m & ~sda_pull & ~comp_pull;
  int checks = 0, errors = 0;
  localparam logic [7:0] ARA_BYTE = {7'b0001100, 1'b1};

  alert_resp_target uut (.clk(clk), .rst_n(rst_n), .fault(fault), .mask(mask),
    .dev_addr(dev_addr), .scl(scl), .sda(sda_line), .sda_pull(sda_pull), .alert_pull(alert_pull));

  always #4 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hp(); repeat (4) @(negedge clk); endtask
  task automatic bus_start(); scl = 1; sda_m = 1; hp(); sda_m = 0; hp(); scl = 0; hp(); endtask
  task automatic bus_stop(); sda_m = 0; hp(); scl = 1; hp(); sda_m = 1; hp(); endtask
  task automatic wbit(input logic b); sda_m = b; hp(); scl = 1; hp(); hp(); scl = 0; hp(); endtask
  task automatic rbit(input logic cb, output logic v);
    sda_m = 1; comp_pull = cb; hp(); scl = 1; hp(); v = sda_line; hp(); scl = 0; comp_pull = 0; hp();
  endtask

  task automatic wbyte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
  endtask

  task automatic ara(input logic ce, input logic [6:0] ca, output logic ack, output logic [7:0] rb);
    logic v, clost;
    logic [7:0] cb;
    cb = {ca, 1'b1};
    clost = 0;
    bus_start();
    wbyte(ARA_BYTE);
    rbit(ce, v);
    ack = ~v;
    for (int i = 7; i >= 0; i--) begin
      rbit(ce & ~clost & ~cb[i], v);
      if (ce && cb[i] && !v) clost = 1;
      rb[i] = v;
    end
    wbit(1'b1);
    bus_stop();
  endtask

  task automatic arm();
    fault = 0; mask = 8'h01; repeat (2) @(negedge clk);
    fault = 8'h01; repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic ack, v;
    logic [7:0] rb;
    logic [6:0] alist [4];
    alist = '{7'h01, 7'h2A, 7'h55, 7'h7E};

    repeat (3) @(negedge clk);
    check(alert_pull == 0, "R2 reset alert", alert_pull, 0);
    check(sda_pull == 0, "R2 reset sda", sda_pull, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int mi = 0; mi < 16; mi++) begin
      for (int f = 0; f < 256; f++) begin
        fault = 0; mask = 8'(mi * 17); repeat (2) @(negedge clk);
        fault = 8'(f); repeat (2) @(negedge clk);
        check(alert_pull == |(fault & mask), mi == 0 ? "R2 mask zero" : "R1 masked alert",
              alert_pull, |(fault & mask));
      end
      fault = 8'hFF; repeat (2) @(negedge clk);
      fault = 0; repeat (2) @(negedge clk);
      check(alert_pull == 0, "R1 cleared", alert_pull, 0);
    end

    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 5; c++) begin
        logic ce;
        logic [6:0] ca;
        logic [7:0] exp_b;
        logic win;
        ce = (c < 4);
        ca = ce ? alist[c] : 7'h7F;
        dev_addr = alist[d];
        arm();
        ara(ce, ca, ack, rb);
        win = !ce || (dev_addr <= ca);
        exp_b = {(ce && ca < dev_addr) ? ca : dev_addr, 1'b1};
        check(ack == 1, "R3 ack when pending", ack, 1);
        check(rb == exp_b, ce ? "R5 arbitrated byte" : "R4 reply byte", rb, exp_b);
        check(alert_pull == !win, win ? "R6 released after win" : "R5 kept after loss",
              alert_pull, !win);
      end
    end

    dev_addr = 7'h55;
    fault = 8'hFF; mask = 0; repeat (2) @(negedge clk);
    ara(1'b0, 7'h7F, ack, rb);
    check(ack == 0, "R3 no ack without alert", ack, 0);
    check(rb == 8'hFF, "R3 bus released", rb, 8'hFF);

    arm();
    ara(1'b0, 7'h7F, ack, rb);
    check(alert_pull == 0, "R6 served", alert_pull, 0);
    repeat (50) @(negedge clk);
    check(alert_pull == 0, "R8 held fault no rearm", alert_pull, 0);
    mask = 8'h03; fault = 8'h02; repeat (2) @(negedge clk);
    fault = 8'h03; repeat (2) @(negedge clk);
    check(alert_pull == 0, "R8 reshuffled fault no rearm", alert_pull, 0);
    fault = 0; repeat (2) @(negedge clk);
    fault = 8'h02; repeat (2) @(negedge clk);
    check(alert_pull == 1, "R8 new edge rearms", alert_pull, 1);

    for (int rw = 0; rw < 2; rw++) begin
      arm();
      bus_start(); wbyte({dev_addr ^ 7'h01, 1'(rw)}); rbit(1'b0, v); bus_stop();
      check(alert_pull == 1, "R7 other address keeps alert", alert_pull, 1);
      bus_start(); wbyte({dev_addr, 1'(rw)}); rbit(1'b0, v); bus_stop();
      check(v == 1, "R7 own address not acked", v, 1);
      check(alert_pull == 0, "R7 own address releases", alert_pull, 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule